// File: doc/BRIEF.md
# Forwarded-DMA Responder for a Private Cache Line

This block is the per-line coherence slice of a private first-level cache that answers forwarded read requests. It holds one line's coherence state, the line's data and a single writeback buffer entry. When a forwarded request arrives, it works out whether data must be returned and from where: the cache line or the writeback buffer. For a DMA-originated request it also works out that a separate acknowledgement must go to the second-level bank that owns the address.

A forwarded DMA read produces two messages. The data goes to the DMA requestor and an acknowledgement goes to the second-level bank. An ordinary forwarded read produces only the data. The data message always leaves first. The request is consumed only once every message it owes has been accepted on its valid/ready output. The coherence state is written by the surrounding controller through an update port. Moving the line into a writeback-pending state snapshots the line into the writeback buffer.

Top module: `fwd_dma_resp`

## Requirements
- R1: After reset the line state is invalid and neither `dat_valid` nor `ack_valid` is asserted.
- R2: State codes are I=0, S=1, O=2, M=3, MM=4, SM=5, OM=6. In S, O, M, MM, SM or OM, a request with `req_dma`=1 returns the line data, `req_addr` and `req_src_id` on the data port, then sends an acknowledgement. The line state is left unchanged.
- R3: Writeback-pending state codes are MI=7, SI=8, OI=9. In these states a request with `req_dma`=1 takes its data from the writeback buffer, not the line, and still sends the acknowledgement.
- R4: Requestor type codes are L1=0, L2=1, DIR=2, DMA=3. In a writeback-pending state, data is returned only when the requestor type is L1 or DMA. Types L2 and DIR get no data message, though a DMA request still gets its acknowledgement.
- R5: Every acknowledgement carries an ack count of 1, a clear dirty flag, and `ack_short`=1 to mark the short control-response size.
- R6: The acknowledgement's bank index is the `BANK_BITS` address bits starting at bit `BANK_LOW`.
- R7: A request with `req_dma`=0 returns data exactly as in R2 to R4 but sends no acknowledgement.
- R8: The data message of a request is accepted before its acknowledgement is offered. `dat_valid` and `ack_valid` are never high together.
- R9: `req_ready` rises only in the cycle in which the last message owed by the request is accepted. A stalled output holds its valid and payload stable.
- R10: In state I, or with any state code above 9, a request is consumed at once with no message on either output.
- R11: The writeback buffer captures the line data when the state moves from a non-writeback state into MI, SI or OI. Later writes to the line data do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Write a new line state |
| upd_state | input | 4 | New line state code |
| upd_data_we | input | 1 | Write the line data |
| upd_data | input | DATA_W | New line data |
| req_valid | input | 1 | Forwarded request present |
| req_ready | output | 1 | Request consumed this cycle |
| req_dma | input | 1 | 1 = DMA read, 0 = ordinary read |
| req_src_type | input | 2 | Requestor type code |
| req_src_id | input | ID_W | Requestor identifier |
| req_addr | input | ADDR_W | Line address |
| dat_valid | output | 1 | Data message valid |
| dat_ready | input | 1 | Data message accepted |
| dat_dest | output | ID_W | Data destination |
| dat_addr | output | ADDR_W | Data address |
| dat_data | output | DATA_W | Returned line data |
| ack_valid | output | 1 | Acknowledgement valid |
| ack_ready | input | 1 | Acknowledgement accepted |
| ack_bank | output | BANK_BITS | Destination second-level bank |
| ack_addr | output | ADDR_W | Acknowledged address |
| ack_count | output | ACK_W | Ack count (always 1) |
| ack_dirty | output | 1 | Dirty flag (always 0) |
| ack_short | output | 1 | Short control-size marker (always 1) |

## Verification
The bench builds the block with a 16-bit address and 32-bit data. It takes the bank field from three bits starting at bit 4, off the default position, so a wrong slice offset or width shows up as a wrong bank on addresses chosen to differ in those bits. The 3-bit ack count field makes a stray count value visible. Separate stall lengths on the two outputs reach the data-then-acknowledgement ordering and the held payloads.

// File: rtl/fwd_dma_resp.sv
module fwd_dma_resp #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int ID_W      = 4,
  parameter int BANK_LOW  = 6,
  parameter int BANK_BITS = 2,
  parameter int ACK_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic [3:0]           upd_state,
  input  logic                 upd_data_we,
  input  logic [DATA_W-1:0]    upd_data,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_dma,
  input  logic [1:0]           req_src_type,
  input  logic [ID_W-1:0]      req_src_id,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 dat_valid,
  input  logic                 dat_ready,
  output logic [ID_W-1:0]      dat_dest,
  output logic [ADDR_W-1:0]    dat_addr,
  output logic [DATA_W-1:0]    dat_data,
  output logic                 ack_valid,
  input  logic                 ack_ready,
  output logic [BANK_BITS-1:0] ack_bank,
  output logic [ADDR_W-1:0]    ack_addr,
  output logic [ACK_W-1:0]     ack_count,
  output logic                 ack_dirty,
  output logic                 ack_short
);

  localparam logic [3:0] ST_I  = 4'd0;
  localparam logic [3:0] ST_S  = 4'd1;
  localparam logic [3:0] ST_OM = 4'd6;
  localparam logic [3:0] ST_MI = 4'd7;
  localparam logic [3:0] ST_OI = 4'd9;
  localparam logic [1:0] SRC_L1  = 2'd0;
  localparam logic [1:0] SRC_DMA = 2'd3;

  logic [3:0]        st_q;
  logic [DATA_W-1:0] line_q;
  logic [DATA_W-1:0] wbuf_q;
  logic              ack_ph_q;

  logic in_arr, in_wb, upd_wb, need_dat, need_ack;
  logic dat_fire, ack_fire;

  assign in_arr = (st_q >= ST_S) && (st_q <= ST_OM);
  assign in_wb  = (st_q >= ST_MI) && (st_q <= ST_OI);
  assign upd_wb = (upd_state >= ST_MI) && (upd_state <= ST_OI);

  assign need_dat = in_arr ||
                    (in_wb && (req_src_type == SRC_L1 || req_src_type == SRC_DMA));
  assign need_ack = req_dma && (in_arr || in_wb);

  assign dat_valid = req_valid && need_dat && !ack_ph_q;
  assign ack_valid = req_valid && need_ack && (ack_ph_q || !need_dat);
  assign dat_fire  = dat_valid && dat_ready;
  assign ack_fire  = ack_valid && ack_ready;

  always_comb begin
    if (!req_valid)    req_ready = 1'b0;
    else if (need_ack) req_ready = ack_fire;
    else if (need_dat) req_ready = dat_fire;
    else               req_ready = 1'b1;
  end

  assign dat_dest = req_src_id;
  assign dat_addr = req_addr;
  assign dat_data = in_wb ? wbuf_q : line_q;

  assign ack_bank  = req_addr[BANK_LOW +: BANK_BITS];
  assign ack_addr  = req_addr;
  assign ack_count = ACK_W'(1);
  assign ack_dirty = 1'b0;
  assign ack_short = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_I;
      line_q   <= '0;
      wbuf_q   <= '0;
      ack_ph_q <= 1'b0;
    end else begin
      if (upd_valid) begin
        st_q <= upd_state;
        if (upd_wb && !in_wb) wbuf_q <= line_q;
      end
      if (upd_data_we) line_q <= upd_data;
      if (req_valid && req_ready)   ack_ph_q <= 1'b0;
      else if (dat_fire && need_ack) ack_ph_q <= 1'b1;
    end
  end

endmodule

// File: rtl/fwd_dma_resp_chk.sv
module fwd_dma_resp_chk #(
  parameter int DATA_W    = 64,
  parameter int ID_W      = 4,
  parameter int BANK_BITS = 2,
  parameter int ACK_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           st,
  input logic                 upd_valid,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_dma,
  input logic                 dat_valid,
  input logic                 dat_ready,
  input logic [ID_W-1:0]      dat_dest,
  input logic [DATA_W-1:0]    dat_data,
  input logic                 ack_valid,
  input logic                 ack_ready,
  input logic [BANK_BITS-1:0] ack_bank,
  input logic [ACK_W-1:0]     ack_count,
  input logic                 ack_dirty,
  input logic                 ack_short
);

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_valid && ack_valid));

  // R5
  ack_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_count == ACK_W'(1) && !ack_dirty && ack_short));

  // R9
  dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready && !upd_valid) |=>
      (dat_valid && $stable(dat_data) && $stable(dat_dest)));

  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready && !upd_valid) |=> (ack_valid && $stable(ack_bank)));

  // R2
  state_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !upd_valid) |=> (st == $past(st)));

  // R2
  dma_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_dma && st >= 4'd1 && st <= 4'd9) |->
      (ack_valid && ack_ready));

endmodule

bind fwd_dma_resp fwd_dma_resp_chk #(
  .DATA_W(DATA_W), .ID_W(ID_W), .BANK_BITS(BANK_BITS), .ACK_W(ACK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .upd_valid(upd_valid),
  .req_valid(req_valid), .req_ready(req_ready), .req_dma(req_dma),
  .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_dest(dat_dest),
  .dat_data(dat_data), .ack_valid(ack_valid), .ack_ready(ack_ready),
  .ack_bank(ack_bank), .ack_count(ack_count), .ack_dirty(ack_dirty),
  .ack_short(ack_short)
);

// File: tb/fwd_dma_resp_tb.sv
module fwd_dma_resp_tb;
  localparam int ADDR_W = 16, DATA_W = 32, ID_W = 4;
  localparam int BANK_LOW = 4, BANK_BITS = 3, ACK_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid = 0, upd_data_we = 0;
  logic [3:0] upd_state = 0;
  logic [DATA_W-1:0] upd_data = 0;
  logic req_valid = 0, req_dma = 0;
  logic [1:0] req_src_type = 0;
  logic [ID_W-1:0] req_src_id = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic req_ready, dat_valid, ack_valid, ack_dirty, ack_short;
  logic dat_ready = 0, ack_ready = 0;
  logic [ID_W-1:0] dat_dest;
  logic [ADDR_W-1:0] dat_addr, ack_addr;
  logic [DATA_W-1:0] dat_data;
  logic [BANK_BITS-1:0] ack_bank;
  logic [ACK_W-1:0] ack_count;

  always #5 clk = ~clk;

  fwd_dma_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .BANK_LOW(BANK_LOW),
                 .BANK_BITS(BANK_BITS), .ACK_W(ACK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_state(upd_state),
    .upd_data_we(upd_data_we), .upd_data(upd_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_dma(req_dma), .req_src_type(req_src_type),
    .req_src_id(req_src_id), .req_addr(req_addr), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_dest(dat_dest), .dat_addr(dat_addr),
    .dat_data(dat_data), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_bank(ack_bank), .ack_addr(ack_addr), .ack_count(ack_count),
    .ack_dirty(ack_dirty), .ack_short(ack_short));

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_state = 0;
  logic [DATA_W-1:0] m_line = '0, m_wbuf = '0;

  function automatic bit is_arr(int s); return s >= 1 && s <= 6; endfunction
  function automatic bit is_wb(int s);  return s >= 7 && s <= 9; endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic upd(int st, bit we, logic [DATA_W-1:0] d);
    upd_valid = 1; upd_state = 4'(st); upd_data_we = we; upd_data = d;
    @(posedge clk);
    if (is_wb(st) && !is_wb(m_state)) m_wbuf = m_line;
    m_state = st;
    if (we) m_line = d;
    @(negedge clk);
    upd_valid = 0; upd_data_we = 0;
  endtask

  task automatic line_write(logic [DATA_W-1:0] d);
    upd_data_we = 1; upd_data = d;
    @(posedge clk);
    m_line = d;
    @(negedge clk);
    upd_data_we = 0;
  endtask

  task automatic run_req(string tag, bit dma, int stype, int id, int addr,
                         int dly_d, int dly_a);
    bit need_d, need_a, ph, done, exp_dv, exp_av, exp_pop;
    int dc, ac, guard;
    logic [DATA_W-1:0] exp_data;
    need_d = is_arr(m_state) || (is_wb(m_state) && (stype == 0 || stype == 3));
    need_a = dma && (is_arr(m_state) || is_wb(m_state));
    exp_data = is_wb(m_state) ? m_wbuf : m_line;
    ph = 0; done = 0; dc = 0; ac = 0; guard = 0;
    req_valid = 1; req_dma = dma; req_src_type = 2'(stype);
    req_src_id = ID_W'(id); req_addr = ADDR_W'(addr);
    while (!done && guard < 40) begin
      guard++;
      dat_ready = (dc >= dly_d);
      ack_ready = (ac >= dly_a);
      #1;
      exp_dv = need_d && !ph;
      exp_av = need_a && (ph || !need_d);
      exp_pop = need_a ? (exp_av && ack_ready) : (need_d ? (exp_dv && dat_ready) : 1'b1);
      check(is_wb(m_state) && !need_d ? "R4" : tag, "dat_valid", longint'(dat_valid), longint'(exp_dv));
      check("R8", "ack_valid", longint'(ack_valid), longint'(exp_av));
      check("R9", "req_ready", longint'(req_ready), longint'(exp_pop));
      if (exp_dv) begin
        check(tag, "dat_data", longint'(dat_data), longint'(exp_data));
        check(tag, "dat_dest", longint'(dat_dest), longint'(id));
        check(tag, "dat_addr", longint'(dat_addr), longint'(addr & 16'hffff));
      end
      if (exp_av) begin
        check("R6", "ack_bank", longint'(ack_bank), longint'((addr >> BANK_LOW) & ((1 << BANK_BITS) - 1)));
        check("R5", "ack_count", longint'(ack_count), 1);
        check("R5", "ack_dirty", longint'(ack_dirty), 0);
        check("R5", "ack_short", longint'(ack_short), 1);
      end
      if (exp_dv && !dat_ready) dc++;
      if (exp_av && !ack_ready) ac++;
      @(posedge clk);
      if (exp_pop) done = 1;
      else if (exp_dv && dat_ready && need_a) ph = 1;
      @(negedge clk);
    end
    if (!done) check("R9", "request completion", 0, 1);
    req_valid = 0; dat_ready = 0; ack_ready = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", "dat_valid after reset", longint'(dat_valid), 0);
    check("R1", "ack_valid after reset", longint'(ack_valid), 0);
    @(negedge clk);
    // R10: invalid state drops request
    run_req("R10", 1, 3, 2, 16'h0120, 0, 0);
    upd(12, 1, 32'hdead0001);
    run_req("R10", 1, 3, 2, 16'h0120, 0, 0);
    // R2 / R6: every array-backed state
    for (int s = 1; s <= 6; s++) begin
      upd(s, 1, 32'hA0000000 + 32'(s));
      run_req("R2", 1, 3, s + 1, (s * 16) + 16'h0300, s % 3, (s + 1) % 3);
      run_req("R2", 1, 3, s + 2, (s * 16) + 16'h0700, 0, 0);
    end
    // R7: ordinary reads, no ack
    upd(3, 1, 32'h12345678);
    run_req("R7", 0, 0, 9, 16'h00f0, 0, 0);
    run_req("R7", 0, 1, 4, 16'h0050, 2, 0);
    // R8 / R9: long stalls on both outputs
    run_req("R8", 1, 3, 7, 16'h0070, 4, 3);
    run_req("R9", 1, 3, 6, 16'h0060, 1, 5);
    // R3 / R11: writeback states take buffered data
    for (int s = 7; s <= 9; s++) begin
      upd(3, 1, 32'hB0000000 + 32'(s));
      upd(s, 0, '0);
      line_write(32'hCCCC0000 + 32'(s));
      run_req("R11", 1, 3, 3, 16'h0040 + (s * 16), 1, 1);
      run_req("R3", 1, 0, 5, 16'h0010, 0, 2);
      // R4: L2 and DIR requestors get no data
      run_req("R4", 1, 1, 8, 16'h0030, 0, 0);
      run_req("R4", 1, 2, 8, 16'h00a0, 0, 1);
      run_req("R4", 0, 2, 8, 16'h00b0, 0, 0);
      run_req("R7", 0, 0, 2, 16'h00c0, 0, 0);
    end
    // R11: moving between writeback states keeps the buffer
    upd(8, 1, 32'hEEEE0000);
    run_req("R11", 1, 3, 1, 16'h0020, 0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule